// File: doc/BRIEF.md
# Audio CPU I/O Register Page

This block sits beside the 8-bit core of an audio subsystem and serves the sixteen byte addresses from 0x00F0 to 0x00FF. It turns CPU reads and writes at those addresses into side effects on three groups of logic. The first group is the timer unit, which gets enables, restart pulses and period values, and whose 4-bit tick counters are kept here. The second is a DSP register port, reached through an index and a data address. The third is four communication port bytes that a host side fills. Every other address passes through to the RAM array.

The block also owns a boot ROM overlay that covers the top 64 bytes of the 64 KB space. While the overlay is on, CPU reads in that window return ROM data. CPU writes there still go to RAM, so the RAM copy shows through once the overlay is switched off. A single control byte holds the timer enables, the port-clear requests and the overlay switch.

Read data is combinational in the cycle the read strobe is high. Side effects of a read, such as a counter clear, take hold at the clock edge that ends that cycle.

Top module: `snd_io_page`

## Requirements
- R1: After a synchronous reset the timers are disabled, the ROM overlay is on, and the port bytes, DSP index, timer periods and timer counters are all zero.
- R2: Writing control address 0xF1 sets timer enable i from data bit i (i = 0..2). A timer that goes from disabled to enabled gets a one-cycle `tmr_start` pulse in the write cycle, and its counter restarts at 0. Rewriting the enable of a timer that is already on leaves its counter untouched.
- R3: A write to 0xF1 with bit 4 set zeroes port bytes 0xF4 and 0xF5. A write with bit 5 set zeroes 0xF6 and 0xF7. A clear takes priority over a host write in the same cycle.
- R4: Bit 7 of a 0xF1 write turns the overlay on (1) or off (0). With the overlay on, reads in 0xFFC0 to 0xFFFF return `rom_rdata` and `rom_sel` is high. With it off, and at any address below 0xFFC0, reads return `ram_rdata`.
- R5: A write to any address outside 0x00F0 to 0x00FF raises `ram_we` with `ram_addr` and `ram_wdata` taken from the CPU, and this includes the ROM window whatever the overlay state.
- R6: Address 0xF2 stores the DSP index and reads it back. A read at 0xF3 raises `dsp_rd` with `dsp_addr` equal to the index with bit 7 cleared and returns `dsp_rdata`.
- R7: A write at 0xF3 raises `dsp_wr` carrying the CPU data only when index bit 7 is 0. Otherwise the write is dropped.
- R8: Writes to 0xF0 have no effect. Reads of 0xF0, 0xF1 and 0xFA to 0xFC return 0. CPU writes to 0xF4 to 0xF7 are ignored, raise no `ram_we`, and reads there return the port bytes.
- R9: Addresses 0xF8 and 0xF9 behave as RAM: reads return `ram_rdata` and writes raise `ram_we`.
- R10: A write to 0xFA + i loads `tmr_period` byte i. A read of 0xFD + i returns counter i in the low 4 bits and clears it. A write there clears it too.
- R11: Counter i steps by one modulo 16 on each `tmr_tick[i]` pulse while timer i is enabled, and ignores ticks while it is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| ram_rdata | input | 8 | Data from the RAM array at `ram_addr` |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| rom_rdata | input | 8 | Boot ROM data at `rom_addr` |
| rom_addr | output | 6 | Boot ROM byte index |
| rom_sel | output | 1 | CPU address falls in the ROM window and the overlay is on |
| dsp_rdata | input | 8 | DSP register read data |
| dsp_addr | output | 7 | DSP register number |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_rd | output | 1 | DSP register read strobe |
| dsp_wr | output | 1 | DSP register write strobe |
| port_we | input | 1 | Host write strobe for a port byte |
| port_idx | input | 2 | Host port byte select (0 = 0xF4 .. 3 = 0xF7) |
| port_data | input | 8 | Host port byte value |
| tmr_tick | input | 3 | Per-timer period-elapsed pulses from the timer unit |
| tmr_en | output | 3 | Timer enables |
| tmr_start | output | 3 | One-cycle restart pulse per timer |
| tmr_period | output | 24 | Timer period bytes, timer i in bits 8i+7..8i |

## Verification
The bench builds the block with its defaults: three timers, 4-bit counters and a 6-bit ROM window. With 4-bit counters, a run of seventeen ticks is enough to show the modulo-16 wrap. With the 6-bit window, both edges of the overlay can be probed directly, at 0xFFBF just below it and at 0xFFC0 to 0xFFFF inside it. Three timers give one enabled and one disabled timer side by side, so ignored ticks and an enable restart can both be seen through the counter reads.

// File: rtl/snd_io_pkg.sv
package snd_io_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Control byte bit positions
    localparam int CTL_CLR_LO = 4;
    localparam int CTL_CLR_HI = 5;
    localparam int CTL_ROM    = 7;

    typedef enum logic [3:0] {
        RK_MEM,
        RK_TEST,
        RK_CTRL,
        RK_DIDX,
        RK_DDAT,
        RK_PORT,
        RK_SCRATCH,
        RK_TPER,
        RK_TCNT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] sub;
        logic       in_rom;
    } dec_t;

    function automatic logic port_pair_hi(input int idx);
        return idx >= 2;
    endfunction

endpackage

// File: rtl/snd_io_decode.sv
module snd_io_decode
    import snd_io_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int ROM_AW = 6
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    localparam logic [AW-9:0] HI_ZERO = '0;

    logic [3:0] off_per;
    logic [3:0] off_cnt;

    always_comb begin
        off_per    = addr[3:0] - 4'hA;
        off_cnt    = addr[3:0] - 4'hD;
        dec        = '0;
        dec.kind   = RK_MEM;
        dec.in_rom = &addr[AW-1:ROM_AW];
        if (addr[AW-1:8] == HI_ZERO && addr[7:4] == 4'hF) begin
            unique case (addr[3:0])
                4'h0: dec.kind = RK_TEST;
                4'h1: dec.kind = RK_CTRL;
                4'h2: dec.kind = RK_DIDX;
                4'h3: dec.kind = RK_DDAT;
                4'h4, 4'h5, 4'h6, 4'h7: begin
                    dec.kind = RK_PORT;
                    dec.sub  = addr[1:0];
                end
                4'h8, 4'h9: dec.kind = RK_SCRATCH;
                4'hA, 4'hB, 4'hC: begin
                    dec.kind = RK_TPER;
                    dec.sub  = off_per[1:0];
                end
                default: begin
                    dec.kind = RK_TCNT;
                    dec.sub  = off_cnt[1:0];
                end
            endcase
        end
    end

endmodule

// File: rtl/snd_io_ctrl.sv
module snd_io_ctrl
    import snd_io_pkg::*;
#(
    parameter int NUM_TIMERS = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_ctrl,
    input  logic [NUM_TIMERS-1:0] ten_bits,
    input  logic                  clr_lo,
    input  logic                  clr_hi,
    input  logic                  rom_bit,
    input  logic                  host_we,
    input  logic [1:0]            host_idx,
    input  logic [DATA_W-1:0]     host_data,
    output logic [NUM_TIMERS-1:0] ten,
    output logic [NUM_TIMERS-1:0] tstart,
    output logic                  rom_on,
    output logic [4*DATA_W-1:0]   port_bytes
);
    localparam int NUM_PORTS = 4;

    logic [NUM_TIMERS-1:0] ten_q;
    logic                  rom_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ten_q <= '0;
            rom_q <= 1'b1;
        end else if (wr_ctrl) begin
            ten_q <= ten_bits;
            rom_q <= rom_bit;
        end
    end

    assign ten    = ten_q;
    assign rom_on = rom_q;
    assign tstart = wr_ctrl ? (ten_bits & ~ten_q) : '0;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [DATA_W-1:0] byte_q;
        logic              clr_this;

        assign clr_this = wr_ctrl && (port_pair_hi(p) ? clr_hi : clr_lo);

        always_ff @(posedge clk) begin
            if (rst || clr_this) begin
                byte_q <= '0;
            end else if (host_we && host_idx == 2'(p)) begin
                byte_q <= host_data;
            end
        end

        assign port_bytes[p*DATA_W +: DATA_W] = byte_q;
    end

    p_port_clear_r3 : assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && clr_lo) |=> (port_bytes[2*DATA_W-1:0] == '0));

    p_rom_follow_r4 : assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (rom_on == $past(rom_bit)));

endmodule

// File: rtl/snd_io_timer_slot.sv
module snd_io_timer_slot
    import snd_io_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic              per_we,
    input  logic [DATA_W-1:0] per_data,
    input  logic              cnt_rd,
    input  logic              cnt_wr,
    output logic [DATA_W-1:0] period_o,
    output logic [CNT_W-1:0]  count_o
);
    logic [DATA_W-1:0] per_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= '0;
        end else if (per_we) begin
            per_q <= per_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start_i || cnt_rd || cnt_wr) begin
            cnt_q <= '0;
        end else if (en_i && tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign period_o = per_q;
    assign count_o  = cnt_q;

    p_cnt_clear_r10 : assert property (@(posedge clk) disable iff (rst)
        (cnt_rd || cnt_wr) |=> (count_o == '0));

    p_start_zero_r2 : assert property (@(posedge clk) disable iff (rst)
        start_i |=> (count_o == '0));

    p_tick_ignored_r11 : assert property (@(posedge clk) disable iff (rst)
        (!en_i) |=> ((count_o == $past(count_o)) || (count_o == '0)));

endmodule

// File: rtl/snd_io_page.sv
module snd_io_page
    import snd_io_pkg::*;
#(
    parameter int NUM_TIMERS = 3,
    parameter int CNT_W      = 4,
    parameter int ROM_AW     = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [DATA_W-1:0]            cpu_wdata,
    input  logic                         cpu_rd,
    input  logic                         cpu_wr,
    output logic [DATA_W-1:0]            cpu_rdata,
    input  logic [DATA_W-1:0]            ram_rdata,
    output logic [ADDR_W-1:0]            ram_addr,
    output logic [DATA_W-1:0]            ram_wdata,
    output logic                         ram_we,
    input  logic [DATA_W-1:0]            rom_rdata,
    output logic [ROM_AW-1:0]            rom_addr,
    output logic                         rom_sel,
    input  logic [DATA_W-1:0]            dsp_rdata,
    output logic [DATA_W-2:0]            dsp_addr,
    output logic [DATA_W-1:0]            dsp_wdata,
    output logic                         dsp_rd,
    output logic                         dsp_wr,
    input  logic                         port_we,
    input  logic [1:0]                   port_idx,
    input  logic [DATA_W-1:0]            port_data,
    input  logic [NUM_TIMERS-1:0]        tmr_tick,
    output logic [NUM_TIMERS-1:0]        tmr_en,
    output logic [NUM_TIMERS-1:0]        tmr_start,
    output logic [NUM_TIMERS*DATA_W-1:0] tmr_period
);
    localparam int PAD_W = DATA_W - CNT_W;

    dec_t              dec;
    logic [DATA_W-1:0] idx_q;
    logic              rom_on;
    logic              wr_ctrl;
    logic [4*DATA_W-1:0] ports;
    logic [CNT_W-1:0]  cnt_w [NUM_TIMERS];

    snd_io_decode #(.AW(ADDR_W), .ROM_AW(ROM_AW)) i_decode (
        .addr (cpu_addr),
        .dec  (dec)
    );

    assign wr_ctrl = cpu_wr && dec.kind == RK_CTRL;

    snd_io_ctrl #(.NUM_TIMERS(NUM_TIMERS)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .ten_bits   (cpu_wdata[NUM_TIMERS-1:0]),
        .clr_lo     (cpu_wdata[CTL_CLR_LO]),
        .clr_hi     (cpu_wdata[CTL_CLR_HI]),
        .rom_bit    (cpu_wdata[CTL_ROM]),
        .host_we    (port_we),
        .host_idx   (port_idx),
        .host_data  (port_data),
        .ten        (tmr_en),
        .tstart     (tmr_start),
        .rom_on     (rom_on),
        .port_bytes (ports)
    );

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        logic hit;
        assign hit = dec.sub == 2'(t);

        snd_io_timer_slot #(.CNT_W(CNT_W)) i_slot (
            .clk      (clk),
            .rst      (rst),
            .en_i     (tmr_en[t]),
            .start_i  (tmr_start[t]),
            .tick_i   (tmr_tick[t]),
            .per_we   (cpu_wr && dec.kind == RK_TPER && hit),
            .per_data (cpu_wdata),
            .cnt_rd   (cpu_rd && dec.kind == RK_TCNT && hit),
            .cnt_wr   (cpu_wr && dec.kind == RK_TCNT && hit),
            .period_o (tmr_period[t*DATA_W +: DATA_W]),
            .count_o  (cnt_w[t])
        );
    end

    // DSP index register
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (cpu_wr && dec.kind == RK_DIDX) begin
            idx_q <= cpu_wdata;
        end
    end

    assign dsp_addr  = idx_q[DATA_W-2:0];
    assign dsp_wdata = cpu_wdata;
    assign dsp_rd    = cpu_rd && dec.kind == RK_DDAT;
    assign dsp_wr    = cpu_wr && dec.kind == RK_DDAT && !idx_q[DATA_W-1];

    // RAM and ROM paths
    assign ram_addr  = cpu_addr;
    assign ram_wdata = cpu_wdata;
    assign ram_we    = cpu_wr && (dec.kind == RK_MEM || dec.kind == RK_SCRATCH);
    assign rom_addr  = cpu_addr[ROM_AW-1:0];
    assign rom_sel   = dec.kind == RK_MEM && dec.in_rom && rom_on;

    // Read data mux
    always_comb begin
        cpu_rdata = '0;
        unique case (dec.kind)
            RK_MEM:     cpu_rdata = rom_sel ? rom_rdata : ram_rdata;
            RK_SCRATCH: cpu_rdata = ram_rdata;
            RK_DIDX:    cpu_rdata = idx_q;
            RK_DDAT:    cpu_rdata = dsp_rdata;
            RK_PORT:    cpu_rdata = ports[dec.sub*DATA_W +: DATA_W];
            RK_TCNT: begin
                for (int t = 0; t < NUM_TIMERS; t++) begin
                    if (dec.sub == 2'(t)) cpu_rdata = {{PAD_W{1'b0}}, cnt_w[t]};
                end
            end
            default:    cpu_rdata = '0;
        endcase
    end

    p_idx_hold_r6 : assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_addr == 16'h00F2) |=> $stable(idx_q));

    p_rom_write_through_r5 : assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && rom_sel) |-> ram_we);

endmodule

// File: tb/test_snd_io_page.sv
module test_snd_io_page;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_rd, cpu_wr;
    logic [7:0]  cpu_rdata;
    logic [7:0]  ram_rdata;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic [7:0]  rom_rdata;
    logic [5:0]  rom_addr;
    logic        rom_sel;
    logic [7:0]  dsp_rdata;
    logic [6:0]  dsp_addr;
    logic [7:0]  dsp_wdata;
    logic        dsp_rd, dsp_wr;
    logic        port_we;
    logic [1:0]  port_idx;
    logic [7:0]  port_data;
    logic [2:0]  tmr_tick;
    logic [2:0]  tmr_en;
    logic [2:0]  tmr_start;
    logic [23:0] tmr_period;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Simple memory models seen by the block
    assign ram_rdata = ram_addr[7:0] ^ 8'h5A;
    assign rom_rdata = 8'hC0 | {2'b00, rom_addr};
    assign dsp_rdata = {1'b0, dsp_addr} + 8'h20;

    snd_io_page i_snd_io_page (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_we(ram_we), .rom_rdata(rom_rdata), .rom_addr(rom_addr),
        .rom_sel(rom_sel), .dsp_rdata(dsp_rdata), .dsp_addr(dsp_addr),
        .dsp_wdata(dsp_wdata), .dsp_rd(dsp_rd), .dsp_wr(dsp_wr),
        .port_we(port_we), .port_idx(port_idx), .port_data(port_data),
        .tmr_tick(tmr_tick), .tmr_en(tmr_en), .tmr_start(tmr_start),
        .tmr_period(tmr_period)
    );

    typedef struct packed {
        logic        is_rd;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h00F1, 8'h00, 8'h00, 4'd8},  // R8 control reads zero
        '{1'b1, 16'h00F0, 8'h00, 8'h00, 4'd8},  // R8
        '{1'b0, 16'h00F0, 8'h55, 8'h00, 4'd8},  // R8 write ignored
        '{1'b1, 16'h00F0, 8'h00, 8'h00, 4'd8},  // R8
        '{1'b1, 16'hFFC5, 8'h00, 8'hC5, 4'd4},  // R4 overlay on
        '{1'b1, 16'hFFFF, 8'h00, 8'hFF, 4'd4},  // R4 top byte
        '{1'b1, 16'hFFBF, 8'h00, 8'hE5, 4'd4},  // R4 just below window
        '{1'b1, 16'h1234, 8'h00, 8'h6E, 4'd5},  // R5 plain RAM
        '{1'b0, 16'h00F2, 8'h3A, 8'h00, 4'd6},  // R6 set index
        '{1'b1, 16'h00F2, 8'h00, 8'h3A, 4'd6},  // R6
        '{1'b1, 16'h00F3, 8'h00, 8'h5A, 4'd6},  // R6 DSP read
        '{1'b1, 16'h00F8, 8'h00, 8'hA2, 4'd9},  // R9
        '{1'b1, 16'h00F9, 8'h00, 8'hA3, 4'd9},  // R9
        '{1'b0, 16'h00FA, 8'h10, 8'h00, 4'd10}, // R10 period load
        '{1'b1, 16'h00FA, 8'h00, 8'h00, 4'd8},  // R8 period reads zero
        '{1'b1, 16'h00FD, 8'h00, 8'h00, 4'd1},  // R1 counter zero
        '{1'b0, 16'h00F1, 8'h00, 8'h00, 4'd4},  // R4 overlay off
        '{1'b1, 16'hFFC5, 8'h00, 8'h9F, 4'd4},  // R4 RAM visible
        '{1'b0, 16'h00F1, 8'h80, 8'h00, 4'd4},  // R4 overlay on again
        '{1'b1, 16'hFFC5, 8'h00, 8'hC5, 4'd4}   // R4
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic rd, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_rd    = rd;
        cpu_wr    = !rd;
        #1;
    endtask

    task automatic bus_end();
        @(negedge clk);
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus(1'b0, a, d);
        bus_end();
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
        bus(1'b1, a, 8'h00);
        chk(req, cpu_rdata, exp);
        bus_end();
    endtask

    task automatic ticks(input int t, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tmr_tick[t] = 1'b1;
            @(negedge clk);
            tmr_tick[t] = 1'b0;
        end
    endtask

    task automatic host(input logic [1:0] i, input logic [7:0] d);
        @(negedge clk);
        port_we = 1'b1; port_idx = i; port_data = d;
        @(negedge clk);
        port_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 0; cpu_wr = 0;
        port_we = 0; port_idx = '0; port_data = '0; tmr_tick = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 tmr_en", tmr_en, 3'b000);
        chk("R1 tmr_period", tmr_period, 24'h0);
        cpu_addr = 16'hFFC0; #1;
        chk("R1 rom_sel", rom_sel, 1'b1);
        rd_chk("R1 idx", 16'h00F2, 8'h00);
        rd_chk("R1 port", 16'h00F6, 8'h00);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            bus(VEC[v].is_rd, VEC[v].addr, VEC[v].data);
            if (VEC[v].is_rd) begin
                checks++;
                if (cpu_rdata !== VEC[v].exp) begin
                    fails++;
                    $display("FAIL R%0d row %0d actual=%h expected=%h",
                             VEC[v].req, v, cpu_rdata, VEC[v].exp);
                end
            end
            bus_end();
        end
        chk("R10 period0", tmr_period[7:0], 8'h10);

        // R5 write into ROM window with overlay on
        bus(1'b0, 16'hFFC3, 8'h77);
        chk("R5 ram_we", ram_we, 1'b1);
        chk("R5 ram_addr", ram_addr, 16'hFFC3);
        chk("R5 ram_wdata", ram_wdata, 8'h77);
        bus_end();

        // R9 scratch write reaches RAM; R8 port write does not
        bus(1'b0, 16'h00F8, 8'h12);
        chk("R9 ram_we", ram_we, 1'b1);
        bus_end();
        bus(1'b0, 16'h00F4, 8'h99);
        chk("R8 port write ram_we", ram_we, 1'b0);
        bus_end();

        // R2 / R11 timer enable and counting
        bus(1'b0, 16'h00F1, 8'h81);
        chk("R2 start pulse", tmr_start, 3'b001);
        bus_end();
        chk("R2 tmr_en", tmr_en, 3'b001);
        ticks(0, 3);
        rd_chk("R11 count 3", 16'h00FD, 8'h03);
        rd_chk("R10 read clears", 16'h00FD, 8'h00);
        ticks(0, 17);
        rd_chk("R11 wrap", 16'h00FD, 8'h01);
        ticks(0, 2);
        bus(1'b0, 16'h00F1, 8'h81);
        chk("R2 no restart", tmr_start, 3'b000);
        bus_end();
        rd_chk("R2 count kept", 16'h00FD, 8'h02);
        ticks(0, 2);
        wr(16'h00F1, 8'h80);
        wr(16'h00F1, 8'h81);
        rd_chk("R2 restart zero", 16'h00FD, 8'h00);
        ticks(1, 3);
        rd_chk("R11 disabled ignores", 16'h00FE, 8'h00);
        ticks(0, 2);
        wr(16'h00FD, 8'h77);
        rd_chk("R10 write clears", 16'h00FD, 8'h00);
        wr(16'h00FB, 8'h80);
        chk("R10 period1", tmr_period[15:8], 8'h80);

        // R3 / R8 ports
        host(2'd0, 8'h11); host(2'd1, 8'h22); host(2'd2, 8'h33); host(2'd3, 8'h44);
        wr(16'h00F4, 8'h99);
        rd_chk("R8 port ignores cpu", 16'h00F4, 8'h11);
        wr(16'h00F1, 8'h90);
        rd_chk("R3 clr F4", 16'h00F4, 8'h00);
        rd_chk("R3 clr F5", 16'h00F5, 8'h00);
        rd_chk("R3 F6 kept", 16'h00F6, 8'h33);
        wr(16'h00F1, 8'hA0);
        rd_chk("R3 clr F7", 16'h00F7, 8'h00);

        // R6 / R7 DSP port
        wr(16'h00F2, 8'h85);
        bus(1'b0, 16'h00F3, 8'hAB);
        chk("R7 dropped", dsp_wr, 1'b0);
        bus_end();
        bus(1'b1, 16'h00F3, 8'h00);
        chk("R6 dsp_rd", dsp_rd, 1'b1);
        chk("R6 masked addr", dsp_addr, 7'h05);
        chk("R6 dsp data", cpu_rdata, 8'h25);
        bus_end();
        wr(16'h00F2, 8'h05);
        bus(1'b0, 16'h00F3, 8'hCD);
        chk("R7 dsp_wr", dsp_wr, 1'b1);
        chk("R7 dsp_wdata", dsp_wdata, 8'hCD);
        bus_end();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule